// File: doc/BRIEF.md
# ATA Programmed-I/O Sector Read Sequencer

This block reads one or more disk sectors through a drive's eight-entry task-file register port. A start pulse hands it a 28-bit logical block address, a sector count, a drive select bit and a command byte. The block then runs the whole programmed-I/O handshake without further help. It polls the status byte until the drive is free, selects the drive, waits for it to report ready and loads the address and count. It then issues the command and moves each sector word by word from the data register onto a valid/ready stream. After every sector it checks the status byte again.

When the last word has been taken, or the read has failed, the block raises `done` for one cycle. It also presents a failure flag, a timeout flag and the captured error byte. Each status wait is bounded by a poll limit supplied at run time, so a drive that hangs cannot stall the block forever.

The controller has these states. `ST_IDLE` waits for start. `ST_WAIT_FREE` polls until the drive is not busy and has no data pending. `ST_SELECT` writes the drive/head byte. `ST_WAIT_READY` polls for ready. `ST_PARAM` writes four parameter bytes. `ST_COMMAND` writes the command byte. `ST_SETTLE` is an idle gap. `ST_WAIT_DATA` polls for a data request. `ST_XFER` moves one sector of words. `ST_CHECK` reads status after the sector. `ST_ERR_FETCH` reads the error byte. `ST_FINISH` drains the output and pulses done.

The forward path runs IDLE→WAIT_FREE→SELECT→WAIT_READY→PARAM→COMMAND→SETTLE→WAIT_DATA→XFER→CHECK. From CHECK the block returns to WAIT_DATA if sectors remain, or goes to FINISH. The failure edges are WAIT_READY/WAIT_DATA/CHECK→FINISH on device fault, WAIT_DATA/CHECK→ERR_FETCH→FINISH on the error bit, and any wait→FINISH on timeout. FINISH returns to IDLE.

Top module: `ata_pio_reader`

## Requirements
- R1: After reset the block makes no register access, `out_valid` and `done` are low. It never asserts `reg_rd` and `reg_wr` together.
- R2: After start, the block reads status (offset 7) until a read shows BSY (bit 7) and DRQ (bit 3) both clear. Only then does it write offset 6 with bits 7:5 = 111, bit 4 = `req_dev` and bits 3:0 = LBA[27:24].
- R3: After the select write, the block polls status until BSY is clear and DRDY (bit 6) is set. It then writes, on consecutive cycles, offset 2 = count, offset 3 = LBA[7:0], offset 4 = LBA[15:8], offset 5 = LBA[23:16] and offset 7 = command, in that order.
- R4: The cycle after the command write carries no register access.
- R5: For each sector the block waits for a status read with BSY clear and DRQ set. It then reads offset 0 exactly SECTOR_WORDS times and passes every word, in order and once, to the stream. While `out_ready` is low, `out_valid` and `out_data` hold.
- R6: When a status read after the command shows ERR (bit 0), the block reads offset 1 once, places it on `err_reg`, reads no further data and finishes with `fail` = 1.
- R7: When a status check shows DF (bit 5), the block finishes with `fail` = 1 and `err_reg` = 0, without reading offset 1.
- R8: A requested count of 0 transfers 2^CNT_W sectors (256 by default).
- R9: If a wait sees poll_limit+1 status reads without its condition, the block finishes with `fail` = 1 and `timed_out` = 1.
- R10: `done` is a one-cycle pulse given only once the output word has been taken. `fail`, `timed_out` and `err_reg` are valid with it and hold until the next start. A clean read ends with `fail` = 0.
- R11: A start pulse while a read is under way is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read (taken in idle only) |
| req_lba | input | 28 | Logical block address |
| req_count | input | CNT_W | Sector count, 0 = 2^CNT_W |
| req_dev | input | 1 | Drive select bit |
| req_cmd | input | 8 | Command byte |
| poll_limit | input | TMR_W | Extra status reads allowed per wait |
| reg_addr | output | 3 | Task-file register offset |
| reg_rd | output | 1 | Register read strobe, data returned same cycle |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Write byte |
| reg_rdata | input | 16 | Read data |
| out_valid | output | 1 | Stream word valid |
| out_data | output | 16 | Stream word |
| out_ready | input | 1 | Stream sink ready |
| done | output | 1 | Read finished pulse |
| fail | output | 1 | Read failed |
| timed_out | output | 1 | Failure was a poll timeout |
| err_reg | output | 8 | Captured error byte |

## Verification
The bench builds the block with SECTOR_WORDS = 8, CNT_W = 8 and TMR_W = 8. Short sectors make a count-0 request practical: it covers all 256 sectors in about two thousand words and proves the sector counter's wrap value. The 8-bit poll limit is set to 50 for normal runs and to 3 or 5 in the timeout cases. That fixes the exact number of status reads at which the idle wait and the post-command wait must give up. A behavioural drive model checks every access in the cycle it happens, against the phase the drive is in.

// File: rtl/ata_pio_pkg.sv
`timescale 1ns/1ps
package ata_pio_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_WAIT_FREE, ST_SELECT, ST_WAIT_READY, ST_PARAM, ST_COMMAND,
        ST_SETTLE, ST_WAIT_DATA, ST_XFER, ST_CHECK, ST_ERR_FETCH, ST_FINISH
    } seq_state_t;

    localparam logic [2:0] OFS_DATA   = 3'd0;
    localparam logic [2:0] OFS_ERROR  = 3'd1;
    localparam logic [2:0] OFS_COUNT  = 3'd2;
    localparam logic [2:0] OFS_LBA0   = 3'd3;
    localparam logic [2:0] OFS_LBA1   = 3'd4;
    localparam logic [2:0] OFS_LBA2   = 3'd5;
    localparam logic [2:0] OFS_DEVICE = 3'd6;
    localparam logic [2:0] OFS_STATUS = 3'd7;

    localparam int SB_BSY  = 7;
    localparam int SB_DRDY = 6;
    localparam int SB_DF   = 5;
    localparam int SB_DRQ  = 3;
    localparam int SB_ERR  = 0;
endpackage

// File: rtl/ata_down_count.sv
`timescale 1ns/1ps
module ata_down_count #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/ata_poll_timer.sv
`timescale 1ns/1ps
module ata_poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    assign expired = run && (cnt == limit);

    // R9: the count never passes the limit while a wait is running
    a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == limit) |=> !(run && $past(run) && cnt == limit + 1'b1));
endmodule

// File: rtl/ata_pio_reader.sv
`timescale 1ns/1ps
module ata_pio_reader
    import ata_pio_pkg::*;
#(
    parameter int SECTOR_WORDS = 256,
    parameter int CNT_W        = 8,
    parameter int TMR_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [27:0]      req_lba,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_dev,
    input  logic [7:0]       req_cmd,
    input  logic [TMR_W-1:0] poll_limit,
    output logic [2:0]       reg_addr,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [7:0]       reg_wdata,
    input  logic [15:0]      reg_rdata,
    output logic             out_valid,
    output logic [15:0]      out_data,
    input  logic             out_ready,
    output logic             done,
    output logic             fail,
    output logic             timed_out,
    output logic [7:0]       err_reg
);
    localparam int WORD_W = $clog2(SECTOR_WORDS + 1);
    localparam int SEC_W  = CNT_W + 1;

    seq_state_t       state, state_n;
    logic [27:0]      lba_q;
    logic [CNT_W-1:0] cnt_q;
    logic             dev_q;
    logic [7:0]       cmd_q;
    logic [1:0]       pidx;
    logic             ov;
    logic [15:0]      odata;
    logic             fail_q, tmo_q;
    logic [7:0]       err_q;

    logic             go_fail, go_tmo, tmr_run, tmr_exp;
    logic             sec_load, sec_dec, sec_last;
    logic             wrd_load, wrd_dec, wrd_last;
    logic [SEC_W-1:0] sec_init;

    wire st_bsy  = reg_rdata[SB_BSY];
    wire st_drdy = reg_rdata[SB_DRDY];
    wire st_df   = reg_rdata[SB_DF];
    wire st_drq  = reg_rdata[SB_DRQ];
    wire st_err  = reg_rdata[SB_ERR];

    assign sec_init = (req_count == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, req_count};

    ata_down_count #(.W(SEC_W)) u_sectors (
        .clk(clk), .rst_n(rst_n), .load(sec_load), .load_val(sec_init),
        .dec(sec_dec), .last(sec_last)
    );

    ata_down_count #(.W(WORD_W)) u_words (
        .clk(clk), .rst_n(rst_n), .load(wrd_load), .load_val(WORD_W'(SECTOR_WORDS)),
        .dec(wrd_dec), .last(wrd_last)
    );

    ata_poll_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(poll_limit), .expired(tmr_exp)
    );

    // next state and register-port strobes
    always_comb begin
        state_n   = state;
        reg_addr  = OFS_DATA;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
        go_fail   = 1'b0;
        go_tmo    = 1'b0;
        tmr_run   = 1'b0;
        sec_load  = 1'b0;
        sec_dec   = 1'b0;
        wrd_load  = 1'b0;
        wrd_dec   = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    sec_load = 1'b1;
                    state_n  = ST_WAIT_FREE;
                end
            end
            ST_WAIT_FREE: begin
                reg_rd   = 1'b1;
                reg_addr = OFS_STATUS;
                tmr_run  = 1'b1;
                if (!st_bsy && !st_drq)
                    state_n = ST_SELECT;
                else if (tmr_exp) begin
                    go_tmo  = 1'b1;
                    state_n = ST_FINISH;
                end
            end
            ST_SELECT: begin
                reg_wr    = 1'b1;
                reg_addr  = OFS_DEVICE;
                reg_wdata = {3'b111, dev_q, lba_q[27:24]};
                state_n   = ST_WAIT_READY;
            end
            ST_WAIT_READY: begin
                reg_rd   = 1'b1;
                reg_addr = OFS_STATUS;
                tmr_run  = 1'b1;
                if (!st_bsy && st_df) begin
                    go_fail = 1'b1;
                    state_n = ST_FINISH;
                end else if (!st_bsy && st_drdy)
                    state_n = ST_PARAM;
                else if (tmr_exp) begin
                    go_tmo  = 1'b1;
                    state_n = ST_FINISH;
                end
            end
            ST_PARAM: begin
                reg_wr = 1'b1;
                unique case (pidx)
                    2'd0: begin reg_addr = OFS_COUNT; reg_wdata = 8'(cnt_q);      end
                    2'd1: begin reg_addr = OFS_LBA0;  reg_wdata = lba_q[7:0];     end
                    2'd2: begin reg_addr = OFS_LBA1;  reg_wdata = lba_q[15:8];    end
                    2'd3: begin reg_addr = OFS_LBA2;  reg_wdata = lba_q[23:16];   end
                    default: ;
                endcase
                if (pidx == 2'd3)
                    state_n = ST_COMMAND;
            end
            ST_COMMAND: begin
                reg_wr    = 1'b1;
                reg_addr  = OFS_STATUS;
                reg_wdata = cmd_q;
                state_n   = ST_SETTLE;
            end
            ST_SETTLE: state_n = ST_WAIT_DATA;
            ST_WAIT_DATA: begin
                reg_rd   = 1'b1;
                reg_addr = OFS_STATUS;
                tmr_run  = 1'b1;
                if (!st_bsy && st_err)
                    state_n = ST_ERR_FETCH;
                else if (!st_bsy && st_df) begin
                    go_fail = 1'b1;
                    state_n = ST_FINISH;
                end else if (!st_bsy && st_drq) begin
                    wrd_load = 1'b1;
                    state_n  = ST_XFER;
                end else if (tmr_exp) begin
                    go_tmo  = 1'b1;
                    state_n = ST_FINISH;
                end
            end
            ST_XFER: begin
                reg_addr = OFS_DATA;
                reg_rd   = !ov || out_ready;
                wrd_dec  = reg_rd;
                if (reg_rd && wrd_last)
                    state_n = ST_CHECK;
            end
            ST_CHECK: begin
                reg_rd   = 1'b1;
                reg_addr = OFS_STATUS;
                if (st_err)
                    state_n = ST_ERR_FETCH;
                else if (st_df) begin
                    go_fail = 1'b1;
                    state_n = ST_FINISH;
                end else if (sec_last)
                    state_n = ST_FINISH;
                else begin
                    sec_dec = 1'b1;
                    state_n = ST_WAIT_DATA;
                end
            end
            ST_ERR_FETCH: begin
                reg_rd   = 1'b1;
                reg_addr = OFS_ERROR;
                state_n  = ST_FINISH;
            end
            ST_FINISH: begin
                if (!ov) begin
                    done    = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register and captured request/result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            lba_q  <= '0;
            cnt_q  <= '0;
            dev_q  <= 1'b0;
            cmd_q  <= 8'h00;
            pidx   <= 2'd0;
            ov     <= 1'b0;
            odata  <= 16'h0000;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
            err_q  <= 8'h00;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && start) begin
                lba_q  <= req_lba;
                cnt_q  <= req_count;
                dev_q  <= req_dev;
                cmd_q  <= req_cmd;
                fail_q <= 1'b0;
                tmo_q  <= 1'b0;
                err_q  <= 8'h00;
            end
            if (go_fail)
                fail_q <= 1'b1;
            if (go_tmo) begin
                fail_q <= 1'b1;
                tmo_q  <= 1'b1;
            end
            if (state == ST_ERR_FETCH) begin
                fail_q <= 1'b1;
                err_q  <= reg_rdata[7:0];
            end
            pidx <= (state == ST_PARAM) ? pidx + 2'd1 : 2'd0;
            if (state == ST_XFER && reg_rd) begin
                ov    <= 1'b1;
                odata <= reg_rdata;
            end else if (out_ready)
                ov <= 1'b0;
        end
    end

    assign out_valid = ov;
    assign out_data  = odata;
    assign fail      = fail_q;
    assign timed_out = tmo_q;
    assign err_reg   = err_q;

    a_r1_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));
    a_r4_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_STATUS) |=> (!reg_rd && !reg_wr));
    a_r5_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r6_no_data_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_ERROR) |=> !(reg_rd && reg_addr == OFS_DATA));
    a_r10_done_drained: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_timeout_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timed_out) |-> fail);
endmodule

// File: tb/ata_pio_reader_test.sv
`timescale 1ns/1ps
module ata_pio_reader_test;
    localparam int SW = 8;
    localparam int M_PRE = 0, M_SEL = 1, M_CMD = 2, M_XFER = 3, M_POST = 4, M_ERR = 5, M_END = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [27:0] req_lba = '0;
    logic [7:0]  req_count = '0;
    logic        req_dev = 1'b0;
    logic [7:0]  req_cmd = '0;
    logic [7:0]  poll_limit = 8'd50;
    logic [2:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [7:0]  reg_wdata;
    logic [15:0] reg_rdata;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ready = 1'b1;
    logic        done, fail, timed_out;
    logic [7:0]  err_reg;

    always #4 clk = ~clk;

    ata_pio_reader #(.SECTOR_WORDS(SW), .CNT_W(8), .TMR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_lba(req_lba), .req_count(req_count),
        .req_dev(req_dev), .req_cmd(req_cmd), .poll_limit(poll_limit), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .done(done),
        .fail(fail), .timed_out(timed_out), .err_reg(err_reg)
    );

    int nchk = 0, nbad = 0;
    int mode = M_END, pre_left = 0, rdy_left = 0, drq_left = 0, drq_wait = 0;
    int sec = 0, widx = 0, nsec = 0, err_sec = -1, df_sec = -1;
    bit saw_idle = 0, rdy_seen = 0, gap = 0, bp_mode = 0;
    int stat_reads = 0, err_reads = 0, accepted = 0, cyc = 0;
    logic [10:0] wq[$];
    logic [15:0] xq[$];
    bit prev_stall = 0;
    logic [15:0] prev_data = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] wv(input int s, input int i);
        return 16'(((s & 255) << 8) | (i & 255)) ^ 16'hA5C3;
    endfunction

    // drive model: read data follows the drive phase
    always_comb begin
        reg_rdata = 16'h0000;
        case (reg_addr)
            3'd0: reg_rdata = wv(sec, widx);
            3'd1: reg_rdata = 16'h0004;
            3'd7: begin
                case (mode)
                    M_PRE:  reg_rdata = (pre_left > 0) ? 16'h0080 : 16'h0000;
                    M_SEL:  reg_rdata = (rdy_left > 0) ? 16'h0000 : 16'h0040;
                    M_CMD:  reg_rdata = (drq_left > 0) ? 16'h0080 : 16'h0048;
                    M_XFER: reg_rdata = 16'h0048;
                    M_POST: reg_rdata = (sec == err_sec) ? 16'h0041 :
                                        (sec == df_sec)  ? 16'h0060 : 16'h0040;
                    default: reg_rdata = 16'h0040;
                endcase
            end
            default: reg_rdata = 16'h0000;
        endcase
    end

    // drive model: every access checked against the phase, on every clock
    always @(posedge clk) begin
        if (rst_n) begin
            if (gap) begin
                chk(!reg_rd && !reg_wr, "R4 access in cycle after command", {reg_rd, reg_wr}, 0);
                gap <= 1'b0;
            end
            if (reg_wr) begin
                if (wq.size() == 0)
                    chk(0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
                else begin
                    chk({reg_addr, reg_wdata} == wq[0], "R3 write order/value", {reg_addr, reg_wdata}, wq[0]);
                    void'(wq.pop_front());
                end
                if (reg_addr == 3'd6) begin
                    chk(mode == M_PRE && saw_idle, "R2 select before drive idle", saw_idle, 1);
                    mode <= M_SEL;
                end else begin
                    chk(rdy_seen, "R3 parameter before ready", rdy_seen, 1);
                    if (reg_addr == 3'd7) begin
                        mode <= M_CMD;
                        drq_left <= drq_wait;
                        gap <= 1'b1;
                    end
                end
            end
            if (reg_rd) begin
                if (reg_addr == 3'd7) begin
                    stat_reads <= stat_reads + 1;
                    case (mode)
                        M_PRE: if (pre_left > 0) pre_left <= pre_left - 1; else saw_idle <= 1'b1;
                        M_SEL: if (rdy_left > 0) rdy_left <= rdy_left - 1; else rdy_seen <= 1'b1;
                        M_CMD: if (drq_left > 0) drq_left <= drq_left - 1;
                               else begin mode <= M_XFER; widx <= 0; end
                        M_POST: begin
                            if (sec == err_sec) mode <= M_ERR;
                            else if (sec == df_sec) mode <= M_END;
                            else begin
                                sec <= sec + 1;
                                if (sec + 1 == nsec) mode <= M_END;
                                else begin mode <= M_CMD; drq_left <= drq_wait; end
                            end
                        end
                        default: ;
                    endcase
                end else if (reg_addr == 3'd0) begin
                    chk(mode == M_XFER, "R5 data read outside data phase", mode, M_XFER);
                    if (mode == M_XFER) begin
                        xq.push_back(wv(sec, widx));
                        widx <= widx + 1;
                        if (widx == SW - 1) mode <= M_POST;
                    end
                end else if (reg_addr == 3'd1) begin
                    chk(mode == M_ERR, "R7 error register read without ERR", mode, M_ERR);
                    err_reads <= err_reads + 1;
                end else
                    chk(0, "R1 read of unexpected offset", reg_addr, 7);
            end
        end
    end

    // sink backpressure, changed just after the edge
    always @(posedge clk) begin
        #1;
        cyc++;
        out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // stream check away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                chk(out_valid && out_data == prev_data, "R5 stream hold under backpressure", out_data, prev_data);
            if (out_valid && out_ready) begin
                accepted++;
                if (xq.size() == 0)
                    chk(0, "R5 extra stream word", out_data, 0);
                else begin
                    chk(out_data == xq[0], "R5 stream word order", out_data, xq[0]);
                    void'(xq.pop_front());
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic run(input string tag, input logic [27:0] lba, input logic [7:0] cnt, input bit dev,
                       input logic [7:0] cmd, input int pre, input int rdy, input int drq,
                       input int esec, input int dsec, input logic [7:0] lim, input bit bp,
                       input bit x_writes, input int x_words, input bit x_fail, input bit x_tmo,
                       input logic [7:0] x_err, input int x_errreads, input int x_stat, input bit extra_start);
        bit got = 0;
        @(negedge clk);
        mode <= M_PRE; pre_left <= pre; rdy_left <= rdy; drq_wait <= drq;
        sec <= 0; widx <= 0; nsec <= (cnt == 0) ? 256 : int'(cnt);
        err_sec <= esec; df_sec <= dsec; saw_idle <= 0; rdy_seen <= 0;
        stat_reads <= 0; err_reads <= 0;
        bp_mode = bp; poll_limit = lim; accepted = 0;
        wq.delete(); xq.delete();
        if (x_writes) begin
            wq.push_back({3'd6, 3'b111, dev, lba[27:24]});
            wq.push_back({3'd2, cnt});
            wq.push_back({3'd3, lba[7:0]});
            wq.push_back({3'd4, lba[15:8]});
            wq.push_back({3'd5, lba[23:16]});
            wq.push_back({3'd7, cmd});
        end
        req_lba = lba; req_count = cnt; req_dev = dev; req_cmd = cmd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 30000 && !got; i++) begin
            if (extra_start && i == 25) begin start = 1'b1; req_lba = 28'h0FFFFFF; end
            else start = 1'b0;
            if (done) begin
                got = 1;
                chk(fail == x_fail, {tag, " R10 fail flag"}, fail, x_fail);
                chk(timed_out == x_tmo, {tag, " R9 timeout flag"}, timed_out, x_tmo);
                chk(err_reg == x_err, {tag, " R6 error byte"}, err_reg, x_err);
            end
            if (!got) @(negedge clk);
        end
        start = 1'b0;
        chk(got, {tag, " R10 done seen"}, got, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!done && !reg_rd && !reg_wr, {tag, " R11 quiet after done"}, {done, reg_rd, reg_wr}, 0);
        end
        chk(fail == x_fail && err_reg == x_err, {tag, " R10 result held"}, {fail, err_reg}, {x_fail, x_err});
        chk(accepted == x_words, {tag, " R5 word count"}, accepted, x_words);
        chk(wq.size() == 0, {tag, " R3 writes left unissued"}, wq.size(), 0);
        chk(xq.size() == 0, {tag, " R5 words not delivered"}, xq.size(), 0);
        chk(err_reads == x_errreads, {tag, " R6 error register reads"}, err_reads, x_errreads);
        if (x_stat >= 0)
            chk(stat_reads == x_stat, {tag, " R9 status read count"}, stat_reads, x_stat);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nbad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!reg_rd && !reg_wr && !out_valid && !done, "R1 reset state", {reg_rd, reg_wr, out_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!reg_rd && !reg_wr && !done, "R1 idle after reset", {reg_rd, reg_wr, done}, 0);
        // R2 R3 R5 R11: waits on every phase, backpressure, stray start mid-run
        run("basic", 28'h1234567, 8'd2, 1'b1, 8'h20, 3, 2, 4, -1, -1, 8'd50, 1'b1,
            1'b1, 2*SW, 1'b0, 1'b0, 8'h00, 0, -1, 1'b1);
        // R2 R5: drive always ready, exact status reads
        run("nowait", 28'h0ABCDEF, 8'd1, 1'b0, 8'h20, 0, 0, 0, -1, -1, 8'd50, 1'b0,
            1'b1, SW, 1'b0, 1'b0, 8'h00, 0, 4, 1'b0);
        // R6: ERR after second sector
        run("err", 28'h0000010, 8'd3, 1'b0, 8'h20, 1, 1, 2, 1, -1, 8'd50, 1'b1,
            1'b1, 2*SW, 1'b1, 1'b0, 8'h04, 1, -1, 1'b0);
        // R7: device fault after first sector
        run("fault", 28'h0000020, 8'd2, 1'b1, 8'h20, 0, 0, 1, -1, 0, 8'd50, 1'b0,
            1'b1, SW, 1'b1, 1'b0, 8'h00, 0, -1, 1'b0);
        // R8: count zero
        run("c0", 28'h0000000, 8'd0, 1'b0, 8'h20, 0, 0, 0, -1, -1, 8'd50, 1'b0,
            1'b1, 256*SW, 1'b0, 1'b0, 8'h00, 0, -1, 1'b0);
        // R9: idle wait never satisfied, limit 5 -> 6 reads
        run("tmo_idle", 28'h0000030, 8'd1, 1'b0, 8'h20, 1000, 0, 0, -1, -1, 8'd5, 1'b0,
            1'b0, 0, 1'b1, 1'b1, 8'h00, 0, 6, 1'b0);
        // R9 R4: data request never arrives, limit 3 -> 1+1+4 reads
        run("tmo_data", 28'h0000040, 8'd1, 1'b1, 8'h20, 0, 0, 1000, -1, -1, 8'd3, 1'b0,
            1'b1, 0, 1'b1, 1'b1, 8'h00, 0, 6, 1'b0);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule